// File: doc/BRIEF.md
# HMAC-SHA1 Engine with Cached Key-Pad States

This block produces HMAC-SHA1 tags for short messages under a key that stays the same across many messages. When a key is loaded, the block runs a setup phase of two SHA1 compressions. The first compresses the key XORed with the inner pad byte, starting from the standard SHA1 initial value. The second does the same with the outer pad byte. The two resulting 160-bit chaining states are kept in registers.

After setup, each message takes exactly two compressions. The inner compression starts from the cached inner state and works on a block that the block pads itself. Its length field counts the 64 key-pad bytes plus the message bytes. The outer compression starts from the cached outer state and works on the 20-byte inner digest, padded with a length field of 672 bits.

A single compression datapath does one SHA1 round per clock cycle and serves all four compression kinds. Messages enter through a valid/ready handshake. Digests leave through a second valid/ready handshake. Keys longer than 64 bytes and messages longer than 55 bytes are outside the block's scope.

Top module: `hmac_sha1_cached`

## Requirements
- R1: While reset is held and right after it, `setup_done`, `msg_ready` and `dig_valid` are all low.
- R2: Key byte i sits in `key_data[511-8i -: 8]`. Key bytes at index `key_len` or above are treated as zero, whatever their value on the port. `key_len` ranges from 0 to 64.
- R3: A `key_load` pulse is honoured in the idle state, during setup, or while waiting for a message. In the cycle after it, `setup_done` is low. `setup_done` rises 160 cycles after the edge on which the pulse is taken. `msg_ready` is high only when `setup_done` is high, no message is in flight and `key_load` is low.
- R4: The digest equals SHA1((K0 xor 0x5C..) || SHA1((K0 xor 0x36..) || M)), where K0 is the zero-padded key. Message byte i is `msg_data[447-8i -: 8]`. Message bytes at index `msg_len` or above are ignored. `msg_len` ranges from 0 to 55. Digest word 0 is `dig_data[159:128]`.
- R5: Any number of messages may be processed after one key load, with no further setup. Each one gets the correct digest from the cached states.
- R6: After a message is accepted, `msg_ready` is low and `dig_valid` goes high exactly 160 cycles after the accepting edge.
- R7: While `dig_valid` is high and `dig_ready` is low, `dig_valid` stays high and `dig_data` holds its value. After the edge with `dig_ready` high, `dig_valid` is low and `msg_ready` is high again.
- R8: A `key_load` pulse between message acceptance and the digest handshake is ignored. The digest uses the old key, `setup_done` stays high, and later messages still use the old key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Pulse to load a new key and start setup |
| key_len | input | 7 | Key length in bytes, 0 to 64 |
| key_data | input | 512 | Key bytes, byte 0 in the top bits |
| setup_done | output | 1 | Cached pad states are valid |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Message can be accepted |
| msg_len | input | 6 | Message length in bytes, 0 to 55 |
| msg_data | input | 448 | Message bytes, byte 0 in the top bits |
| dig_valid | output | 1 | Digest available |
| dig_ready | input | 1 | Digest consumer accepts |
| dig_data | output | 160 | HMAC-SHA1 digest, word 0 in the top bits |

## Verification
The assertions take for granted that `msg_len` never exceeds 55 on an accepted message and that `key_len` never exceeds 64 on a honoured key load. One assertion flags any violation. The bench keeps to these bounds by sweeping message lengths from 0 to 55 and key lengths from 0 to 64 only. It fills the bytes beyond each length with random values, so the masking is exercised without leaving the legal range. Key-load pulses during a message in flight carry random keys with lengths inside the same range.

// File: rtl/hmac_sha1_cached.sv
module hmac_sha1_cached (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load,
  input  logic [6:0]   key_len,
  input  logic [511:0] key_data,
  output logic         setup_done,
  input  logic         msg_valid,
  output logic         msg_ready,
  input  logic [5:0]   msg_len,
  input  logic [447:0] msg_data,
  output logic         dig_valid,
  input  logic         dig_ready,
  output logic [159:0] dig_data
);

  localparam logic [159:0] SHA_IV = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [511:0] PAD_IN  = {64{8'h36}};
  localparam logic [511:0] PAD_OUT = {64{8'h5C}};

  typedef enum logic [2:0] {S_IDLE, S_KEYI, S_KEYO, S_WAIT, S_INNER, S_OUTER, S_DONE} st_t;
  st_t st;

  logic [511:0]       kblk, kmask, mblk, gblk;
  logic [159:0]       ist, ost, hbase, abcde, rnext, fin, gbase;
  logic [15:0][31:0]  w;
  logic [6:0]         rnd;
  logic [31:0]        a, b, c, d, e, f, k, tmp, wsum, wnew;
  logic               running, last, key_ok, msg_fire, go;

  assign running    = st inside {S_KEYI, S_KEYO, S_INNER, S_OUTER};
  assign last       = running && (rnd == 7'd79);
  assign key_ok     = key_load && (st inside {S_IDLE, S_KEYI, S_KEYO, S_WAIT});
  assign msg_ready  = (st == S_WAIT) && !key_load;
  assign msg_fire   = msg_valid && msg_ready;
  assign setup_done = st inside {S_WAIT, S_INNER, S_OUTER, S_DONE};
  assign dig_valid  = (st == S_DONE);

  assign {a, b, c, d, e} = abcde;

  always_comb begin
    if (rnd < 7'd20) begin
      f = (b & c) | (~b & d);
      k = 32'h5A827999;
    end else if (rnd < 7'd40) begin
      f = b ^ c ^ d;
      k = 32'h6ED9EBA1;
    end else if (rnd < 7'd60) begin
      f = (b & c) | (b & d) | (c & d);
      k = 32'h8F1BBCDC;
    end else begin
      f = b ^ c ^ d;
      k = 32'hCA62C1D6;
    end
  end

  assign tmp   = {a[26:0], a[31:27]} + f + e + k + w[0];
  assign rnext = {tmp, a, {b[1:0], b[31:2]}, c, d};
  assign wsum  = w[13] ^ w[8] ^ w[2] ^ w[0];
  assign wnew  = {wsum[30:0], wsum[31]};

  always_comb begin
    for (int i = 0; i < 5; i++)
      fin[32*i +: 32] = hbase[32*i +: 32] + rnext[32*i +: 32];
  end

  always_comb begin
    for (int i = 0; i < 64; i++)
      kmask[511-8*i -: 8] = (7'(i) < key_len) ? key_data[511-8*i -: 8] : 8'h00;
  end

  always_comb begin
    for (int i = 0; i < 56; i++)
      mblk[511-8*i -: 8] = (6'(i) < msg_len) ? msg_data[447-8*i -: 8] :
                           (6'(i) == msg_len) ? 8'h80 : 8'h00;
    mblk[63:0] = {54'd0, 7'd64 + {1'b0, msg_len}, 3'd0};
  end

  always_comb begin
    go    = 1'b0;
    gbase = SHA_IV;
    gblk  = kmask ^ PAD_IN;
    if (key_ok) begin
      go = 1'b1;
    end else if (st == S_KEYI && last) begin
      go   = 1'b1;
      gblk = kblk ^ PAD_OUT;
    end else if (msg_fire) begin
      go    = 1'b1;
      gbase = ist;
      gblk  = mblk;
    end else if (st == S_INNER && last) begin
      go    = 1'b1;
      gbase = ost;
      gblk  = {fin, 32'h80000000, 256'd0, 64'd672};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kblk     <= '0;
      ist      <= '0;
      ost      <= '0;
      hbase    <= '0;
      abcde    <= '0;
      w        <= '0;
      rnd      <= '0;
      dig_data <= '0;
    end else begin
      if (go) begin
        abcde <= gbase;
        hbase <= gbase;
        rnd   <= '0;
        for (int i = 0; i < 16; i++)
          w[i] <= gblk[511-32*i -: 32];
      end else if (running) begin
        abcde <= rnext;
        w     <= {wnew, w[15:1]};
        rnd   <= rnd + 7'd1;
      end

      if (key_ok) begin
        kblk <= kmask;
        st   <= S_KEYI;
      end else begin
        case (st)
          S_KEYI:  if (last) begin ist <= fin; st <= S_KEYO; end
          S_KEYO:  if (last) begin ost <= fin; st <= S_WAIT; end
          S_WAIT:  if (msg_fire) st <= S_INNER;
          S_INNER: if (last) st <= S_OUTER;
          S_OUTER: if (last) begin dig_data <= fin; st <= S_DONE; end
          S_DONE:  if (dig_ready) st <= S_WAIT;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_ready_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> setup_done);

  assert_reload_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> !setup_done);

  assert_len_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_fire |-> (msg_len <= 6'd55));

  assert_key_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |-> (key_len <= 7'd64));

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_fire |=> (!msg_ready && !dig_valid));

  assert_digest_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && !dig_ready) |=> (dig_valid && $stable(dig_data)));

  assert_inflight_key_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && (dig_valid || (setup_done && !msg_ready && !key_ok))) |=> setup_done);

endmodule

// File: tb/hmac_sha1_cached_bench.sv
module hmac_sha1_cached_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         key_load;
  logic [6:0]   key_len;
  logic [511:0] key_data;
  logic         setup_done;
  logic         msg_valid;
  logic         msg_ready;
  logic [5:0]   msg_len;
  logic [447:0] msg_data;
  logic         dig_valid;
  logic         dig_ready;
  logic [159:0] dig_data;

  hmac_sha1_cached u_hmac_sha1_cached (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_len(key_len),
    .key_data(key_data), .setup_done(setup_done), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_len(msg_len), .msg_data(msg_data),
    .dig_valid(dig_valid), .dig_ready(dig_ready), .dig_data(dig_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cur_klen = 0;
  logic [7:0] kb [64];
  logic [7:0] mb [56];
  logic [7:0] sbuf [192];

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] sha1_block(input logic [159:0] h, input logic [511:0] blk);
    logic [31:0] wv [80];
    logic [31:0] va, vb, vc, vd, ve, ff, kk, tt;
    for (int t = 0; t < 16; t++) wv[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 80; t++) wv[t] = rotl(wv[t-3] ^ wv[t-8] ^ wv[t-14] ^ wv[t-16], 1);
    {va, vb, vc, vd, ve} = h;
    for (int t = 0; t < 80; t++) begin
      if (t < 20)      begin ff = (vb & vc) | (~vb & vd);            kk = 32'h5A827999; end
      else if (t < 40) begin ff = vb ^ vc ^ vd;                      kk = 32'h6ED9EBA1; end
      else if (t < 60) begin ff = (vb & vc) | (vb & vd) | (vc & vd); kk = 32'h8F1BBCDC; end
      else             begin ff = vb ^ vc ^ vd;                      kk = 32'hCA62C1D6; end
      tt = rotl(va, 5) + ff + ve + kk + wv[t];
      ve = vd; vd = vc; vc = rotl(vb, 30); vb = va; va = tt;
    end
    return {h[159:128] + va, h[127:96] + vb, h[95:64] + vc, h[63:32] + vd, h[31:0] + ve};
  endfunction

  function automatic logic [159:0] sha1_buf(input int n);
    logic [7:0]   pb [192];
    logic [159:0] h;
    logic [511:0] blk;
    logic [63:0]  bits;
    int total;
    total = ((n + 8) / 64 + 1) * 64;
    bits  = 64'(n) * 64'd8;
    for (int i = 0; i < 192; i++)
      pb[i] = (i < n) ? sbuf[i] : ((i == n) ? 8'h80 : 8'h00);
    for (int j = 0; j < 8; j++) pb[total-1-j] = bits[8*j +: 8];
    h = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
    for (int bI = 0; bI < total / 64; bI++) begin
      for (int i = 0; i < 64; i++) blk[511-8*i -: 8] = pb[64*bI + i];
      h = sha1_block(h, blk);
    end
    return h;
  endfunction

  function automatic logic [159:0] hmac_ref(input int klen, input int mlen);
    logic [159:0] inner;
    for (int i = 0; i < 64; i++) sbuf[i] = ((i < klen) ? kb[i] : 8'h00) ^ 8'h36;
    for (int i = 0; i < mlen; i++) sbuf[64+i] = mb[i];
    inner = sha1_buf(64 + mlen);
    for (int i = 0; i < 64; i++) sbuf[i] = ((i < klen) ? kb[i] : 8'h00) ^ 8'h5C;
    for (int i = 0; i < 20; i++) sbuf[64+i] = inner[159-8*i -: 8];
    return sha1_buf(84);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_key(input int klen);
    for (int i = 0; i < 64; i++) begin
      kb[i] = 8'($urandom);
      key_data[511-8*i -: 8] = (i < klen) ? kb[i] : 8'($urandom);
    end
    key_len  = 7'(klen);
    cur_klen = klen;
    key_load = 1'b1;
    @(negedge clk);
    key_load = 1'b0;
    chk(setup_done == 1'b0, "R3 setup_done after reload", 160'(setup_done), 160'd0);
    chk(msg_ready == 1'b0, "R3 msg_ready after reload", 160'(msg_ready), 160'd0);
    repeat (159) @(negedge clk);
    chk(setup_done == 1'b0, "R3 setup_done at 159", 160'(setup_done), 160'd0);
    @(negedge clk);
    chk(setup_done == 1'b1, "R3 setup_done at 160", 160'(setup_done), 160'd1);
    chk(msg_ready == 1'b1, "R3 msg_ready after setup", 160'(msg_ready), 160'd1);
  endtask

  task automatic do_msg(input int mlen, input int hold, input bit kick, input string tag);
    logic [159:0] exp;
    for (int i = 0; i < 56; i++) begin
      mb[i] = 8'($urandom);
      msg_data[447-8*i -: 8] = (i < mlen) ? mb[i] : 8'($urandom);
    end
    msg_len   = 6'(mlen);
    msg_valid = 1'b1;
    chk(msg_ready == 1'b1, "R3 ready before accept", 160'(msg_ready), 160'd1);
    @(negedge clk);
    msg_valid = 1'b0;
    chk(msg_ready == 1'b0, "R6 busy after accept", 160'(msg_ready), 160'd0);
    if (kick) begin
      key_data = {16{32'($urandom)}};
      key_len  = 7'($urandom_range(0, 64));
      key_load = 1'b1;
      @(negedge clk);
      key_load = 1'b0;
      chk(setup_done == 1'b1, "R8 setup kept", 160'(setup_done), 160'd1);
      repeat (158) @(negedge clk);
    end else begin
      repeat (159) @(negedge clk);
    end
    chk(dig_valid == 1'b0, "R6 digest early", 160'(dig_valid), 160'd0);
    @(negedge clk);
    chk(dig_valid == 1'b1, "R6 digest at 160", 160'(dig_valid), 160'd1);
    exp = hmac_ref(cur_klen, mlen);
    chk(dig_data == exp, tag, dig_data, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(dig_valid && dig_data == exp, "R7 digest held", dig_data, exp);
    end
    dig_ready = 1'b1;
    @(negedge clk);
    dig_ready = 1'b0;
    chk(!dig_valid && msg_ready, "R7 release", {dig_valid, msg_ready}, 160'd1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; key_load = 1'b0; key_len = '0; key_data = '0;
    msg_valid = 1'b0; msg_len = '0; msg_data = '0; dig_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!setup_done && !msg_ready && !dig_valid, "R1 reset outputs",
        {setup_done, msg_ready, dig_valid}, 160'd0);
    rst_n = 1'b1;
    msg_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(!msg_ready && !dig_valid && !setup_done, "R1 no accept before key",
        {setup_done, msg_ready, dig_valid}, 160'd0);
    msg_valid = 1'b0;

    do_key(20);
    for (int m = 0; m < 56; m++) do_msg(m, m % 3, 1'b0, "R4 R5 digest by length");

    for (int kl = 0; kl <= 64; kl++) begin
      do_key(kl);
      do_msg(kl % 56, 0, 1'b0, "R2 digest by key length");
    end

    do_key(64);
    do_msg(10, 5, 1'b1, "R8 digest with in-flight key_load");
    do_msg(55, 0, 1'b0, "R8 old key still cached");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule